// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit up-counters behind a small memory-mapped register port. Writes take one cycle and reads return data combinationally in the same cycle. Each channel has its own control registers, an optional power-of-two clock divider, three compare values and a set of sticky event flags. Each channel drives one level interrupt, formed from the flags that are also enabled.

Software selects one of two counting modes per channel. In free-running mode the counter rolls over at its full range. In interval mode it restarts after a programmed terminal value. The counter can be frozen, and a single write returns it to zero. Flags are sticky until software clears them by writing ones. The usual service routine reads the flag register and writes the same value back.

The word address is `reg_index * 3 + channel`. Each register kind therefore sits at a byte offset that is a multiple of 0x0C, and the three channels follow one another at 4-byte steps.

Top module: `ttc_top`

## Requirements
- R1: Byte address bits [7:2] form a word number w, with reg = w / 3 and channel = w % 3. The register kinds are: 0 clock control, 1 counter control, 2 count value, 3 interval, 4..6 compare 1..3, 7 flags, 8 flag enable. A read of any other reg returns 0, and a write to it changes nothing.
- R2: After reset, every register reads 0 except counter control, which reads 0x0001 (stopped).
- R3: While counter control bit 0 is 1, the count value and the divider phase hold.
- R4: A counter control write with bit 4 set makes the count 0 and the divider phase 0 in the next cycle. This write wins over an increment in the same cycle, and the increment is dropped. Bit 4 always reads 0.
- R5: With counter control bit 1 clear, each count step adds 1. A step from 0xFFFF gives 0 and sets flag bit 4.
- R6: With counter control bit 1 set, a step taken while the count equals the interval register gives 0 and sets flag bit 0. Otherwise the step adds 1.
- R7: Clock control bit 0 enables the divider, and bits [4:1] hold N. The phase counter advances on every running clock. With the divider enabled, a step happens only in a cycle where the low N+1 phase bits are all ones. The first step after a zeroing write therefore comes 2^(N+1) clocks later. With the divider disabled, every running clock is a step.
- R8: With counter control bit 3 set, a step whose new count equals compare k (k = 1..3) sets flag bit k.
- R9: Writing the flag register clears each flag whose data bit is 1. A flag set in the same cycle stays set.
- R10: Each channel's interrupt is high exactly when some flag bit and the same flag-enable bit are both 1.
- R11: Writes to the count value register are ignored. Other register writes take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 3 | Per-channel level interrupt |

## Verification
The hardest situation to reach is a flag clear that lands in the same cycle as a new flag event, where the set must win. The stimulus sets the interval to zero in interval mode, so a wrap event fires on every clock. Any clear write is then forced to collide with a set. The counter overflow is reached the honest way, with one free run of 65,536 steps, and the flag is checked the cycle it appears. A cycle-level model in the bench compares the read data and all interrupts on every clock while the address sweeps the count and flag registers.

// File: rtl/ttc_pkg.sv
package ttc_pkg;

    localparam int MATCH_N  = 3;
    localparam int FLAG_W   = MATCH_N + 2;
    localparam int FLG_INTV = 0;
    localparam int FLG_OVF  = MATCH_N + 1;
    localparam int N_REGS   = 9;

    localparam int CTL_STOP = 0;
    localparam int CTL_INTV = 1;
    localparam int CTL_MEN  = 3;
    localparam int CTL_ZERO = 4;

    typedef enum logic [3:0] {
        RI_CLK  = 4'd0,
        RI_CTL  = 4'd1,
        RI_VAL  = 4'd2,
        RI_INTV = 4'd3,
        RI_M1   = 4'd4,
        RI_M2   = 4'd5,
        RI_M3   = 4'd6,
        RI_STAT = 4'd7,
        RI_IEN  = 4'd8,
        RI_NONE = 4'd15
    } reg_idx_e;

endpackage

// File: rtl/ttc_decode.sv
module ttc_decode
    import ttc_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_sel,
    output reg_idx_e          reg_idx
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    assign word = addr[ADDR_W-1:2];

    always_comb begin
        int w;
        int r;
        int c;
        w = int'(word);
        r = w / NUM_CH;
        c = w % NUM_CH;
        reg_idx = RI_NONE;
        if (r < N_REGS) reg_idx = reg_idx_e'(r[3:0]);
        for (int i = 0; i < NUM_CH; i++) begin
            ch_sel[i] = (r < N_REGS) && (c == i);
        end
    end

endmodule

// File: rtl/ttc_prescale.sv
module ttc_prescale #(
    parameter int PS_N_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clear,
    input  logic              ps_en,
    input  logic [PS_N_W-1:0] ps_n,
    output logic              tick
);
    localparam int PH_W = 2 ** PS_N_W;

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ps_state_s;

    ps_state_s s_d, s_q;
    logic [PH_W-1:0] mask;

    always_comb begin
        s_d  = s_q;
        mask = {PH_W{1'b1}} >> (PH_W - 1 - int'(ps_n));
        tick = run && !clear && (!ps_en || ((s_q.phase & mask) == mask));
        if (clear)    s_d.phase = '0;
        else if (run) s_d.phase = s_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: a zeroing write restarts the divider phase
    p_phase_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> s_q.phase == '0);

endmodule

// File: rtl/ttc_channel.sv
module ttc_channel
    import ttc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PS_N_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_idx_e         reg_idx,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);
    localparam int CLKC_W = PS_N_W + 1;

    typedef struct packed {
        logic [CLKC_W-1:0]             clkc;
        logic                          stop;
        logic                          intv_mode;
        logic                          men;
        logic [CNT_W-1:0]              count;
        logic [CNT_W-1:0]              intv;
        logic [MATCH_N-1:0][CNT_W-1:0] match;
        logic [FLAG_W-1:0]             flags;
        logic [FLAG_W-1:0]             ien;
    } ch_state_s;

    ch_state_s s_d, s_q;
    logic zero_wr;
    logic tick;
    logic [CNT_W-1:0]  nxt;
    logic [FLAG_W-1:0] set_f;
    logic [FLAG_W-1:0] clr_f;

    assign zero_wr = wr_en && (reg_idx == RI_CTL) && wdata[CTL_ZERO];

    ttc_prescale #(.PS_N_W(PS_N_W)) i_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!s_q.stop),
        .clear (zero_wr),
        .ps_en (s_q.clkc[0]),
        .ps_n  (s_q.clkc[CLKC_W-1:1]),
        .tick  (tick)
    );

    always_comb begin
        s_d   = s_q;
        set_f = '0;
        nxt   = s_q.count + 1'b1;
        if (s_q.intv_mode) begin
            if (s_q.count == s_q.intv) begin
                nxt = '0;
                set_f[FLG_INTV] = 1'b1;
            end
        end else if (s_q.count == {CNT_W{1'b1}}) begin
            set_f[FLG_OVF] = 1'b1;
        end
        for (int k = 0; k < MATCH_N; k++) begin
            if (s_q.men && (nxt == s_q.match[k])) set_f[k+1] = 1'b1;
        end
        if (zero_wr)   s_d.count = '0;
        else if (tick) s_d.count = nxt;
        if (!tick) set_f = '0;

        clr_f = (wr_en && reg_idx == RI_STAT) ? wdata[FLAG_W-1:0] : '0;
        s_d.flags = (s_q.flags & ~clr_f) | set_f;

        if (wr_en) begin
            case (reg_idx)
                RI_CLK:  s_d.clkc = wdata[CLKC_W-1:0];
                RI_CTL: begin
                    s_d.stop      = wdata[CTL_STOP];
                    s_d.intv_mode = wdata[CTL_INTV];
                    s_d.men       = wdata[CTL_MEN];
                end
                RI_INTV: s_d.intv = wdata;
                RI_IEN:  s_d.ien  = wdata[FLAG_W-1:0];
                default: begin
                    for (int k = 0; k < MATCH_N; k++) begin
                        if (reg_idx == reg_idx_e'(4'(int'(RI_M1) + k))) s_d.match[k] = wdata;
                    end
                end
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_idx)
            RI_CLK:  rdata[CLKC_W-1:0] = s_q.clkc;
            RI_CTL: begin
                rdata[CTL_STOP] = s_q.stop;
                rdata[CTL_INTV] = s_q.intv_mode;
                rdata[CTL_MEN]  = s_q.men;
            end
            RI_VAL:  rdata = s_q.count;
            RI_INTV: rdata = s_q.intv;
            RI_STAT: rdata[FLAG_W-1:0] = s_q.flags;
            RI_IEN:  rdata[FLAG_W-1:0] = s_q.ien;
            default: begin
                for (int k = 0; k < MATCH_N; k++) begin
                    if (reg_idx == reg_idx_e'(4'(int'(RI_M1) + k))) rdata = s_q.match[k];
                end
            end
        endcase
    end

    assign irq = |(s_q.flags & s_q.ien);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.stop <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: a stopped counter keeps its value unless it is zeroed
    p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stop && !zero_wr) |=> s_q.count == $past(s_q.count));
    // R4: a zeroing write leaves the count at zero
    p_reset_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr |=> s_q.count == '0);
    // R5: the overflow flag appears only together with the wrap to zero
    p_ovf_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flags[FLG_OVF]) |-> s_q.count == '0);
    // R6: the interval flag appears only together with the restart at zero
    p_intv_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flags[FLG_INTV]) |-> s_q.count == '0);

endmodule

// File: rtl/ttc_top.sv
module ttc_top
    import ttc_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter int PS_N_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0]            ch_sel;
    reg_idx_e                     reg_idx;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_rdata;

    ttc_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_dec (
        .addr    (bus_addr),
        .ch_sel  (ch_sel),
        .reg_idx (reg_idx)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ttc_channel #(.CNT_W(CNT_W), .PS_N_W(PS_N_W)) i_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_we && ch_sel[i]),
            .reg_idx (reg_idx),
            .wdata   (bus_wdata),
            .rdata   (ch_rdata[i]),
            .irq     (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel[i]) bus_rdata = bus_rdata | ch_rdata[i];
        end
    end

endmodule

// File: tb/test_ttc_top.sv
module test_ttc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string tag = "R2";

    int m_pre[3], m_cnt[3], m_ctl[3], m_clk[3], m_intv[3], m_st[3], m_ie[3];
    int m_match[3][3];

    always #2 clk = ~clk;

    ttc_top i_ttc_top (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Behavioural reference, one step per clock
    always @(posedge clk) begin
        cyc++;
        for (int ch = 0; ch < 3; ch++) begin
            if (!rst_n) begin
                m_pre[ch] = 0; m_cnt[ch] = 0; m_ctl[ch] = 1; m_clk[ch] = 0;
                m_intv[ch] = 0; m_st[ch] = 0; m_ie[ch] = 0;
                for (int k = 0; k < 3; k++) m_match[ch][k] = 0;
            end else begin
                int w, r, c, nxt, setf, mask, hit, wd;
                bit sel;
                w = int'(bus_addr) >> 2; r = w / 3; c = w % 3; wd = int'(bus_wdata);
                sel = bus_we && (r <= 8) && (c == ch);
                mask = (1 << (((m_clk[ch] >> 1) & 15) + 1)) - 1;
                hit = ((m_clk[ch] & 1) == 0) || ((m_pre[ch] & mask) == mask);
                setf = 0;
                if (sel && r == 1 && (wd & 16) != 0) begin
                    m_cnt[ch] = 0; m_pre[ch] = 0;
                end else if ((m_ctl[ch] & 1) == 0) begin
                    m_pre[ch] = (m_pre[ch] + 1) & 16'hFFFF;
                    if (hit != 0) begin
                        if ((m_ctl[ch] & 2) != 0) begin
                            if (m_cnt[ch] == m_intv[ch]) begin nxt = 0; setf |= 1; end
                            else nxt = (m_cnt[ch] + 1) & 16'hFFFF;
                        end else begin
                            if (m_cnt[ch] == 16'hFFFF) begin nxt = 0; setf |= 16; end
                            else nxt = m_cnt[ch] + 1;
                        end
                        if ((m_ctl[ch] & 8) != 0)
                            for (int k = 0; k < 3; k++) if (nxt == m_match[ch][k]) setf |= (2 << k);
                        m_cnt[ch] = nxt;
                    end
                end
                if (sel && r == 7) m_st[ch] = (m_st[ch] & ~wd & 31) | setf;
                else               m_st[ch] = m_st[ch] | setf;
                if (sel) begin
                    case (r)
                        0: m_clk[ch] = wd & 31;
                        1: m_ctl[ch] = wd & 11;
                        3: m_intv[ch] = wd;
                        4, 5, 6: m_match[ch][r-4] = wd;
                        8: m_ie[ch] = wd & 31;
                        default: ;
                    endcase
                end
            end
        end
    end

    function automatic int model_read(int a);
        int w, r, c;
        w = a >> 2; r = w / 3; c = w % 3;
        case (r)
            0: return m_clk[c];
            1: return m_ctl[c];
            2: return m_cnt[c];
            3: return m_intv[c];
            4, 5, 6: return m_match[c][r-4];
            7: return m_st[c];
            8: return m_ie[c];
            default: return 0;
        endcase
    endfunction

    task automatic compare();
        int exp_rd;
        int exp_irq;
        exp_rd = model_read(int'(bus_addr));
        exp_irq = 0;
        for (int ch = 0; ch < 3; ch++) if ((m_st[ch] & m_ie[ch]) != 0) exp_irq |= (1 << ch);
        n_chk++;
        if (int'(bus_rdata) != exp_rd) begin
            n_fail++;
            $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, bus_addr, bus_rdata, exp_rd);
        end
        n_chk++;
        if (int'(irq) != exp_irq) begin   // R10 interrupt level
            n_fail++;
            $display("FAIL %s/R10 irq actual=%b expected=%b", tag, irq, exp_irq[2:0]);
        end
    endtask

    task automatic step(input bit w, input int a, input int d);
        @(negedge clk);
        compare();
        bus_we = w; bus_addr = a[7:0]; bus_wdata = d[15:0];
    endtask

    task automatic idle(input int a, input int n);
        for (int i = 0; i < n; i++) step(1'b0, a, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected<=150000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        tag = "R2";
        for (int a = 0; a < 8'h68; a += 4) step(1'b0, a, 0);
        tag = "R1";
        step(1'b0, 8'h6C, 0); step(1'b0, 8'hFC, 0);
        step(1'b1, 8'h70, 16'hFFFF); idle(8'h70, 2);

        tag = "R11";
        step(1'b1, 8'h18, 16'h1234); idle(8'h18, 3);

        tag = "R5";
        step(1'b1, 8'h0C, 16'h0010); idle(8'h18, 20);
        tag = "R3";
        step(1'b1, 8'h0C, 16'h0001); idle(8'h18, 10);
        tag = "R4";
        step(1'b1, 8'h0C, 16'h0011); idle(8'h18, 4);
        step(1'b1, 8'h0C, 16'h0010); idle(8'h0C, 3); idle(8'h18, 6);
        step(1'b1, 8'h0C, 16'h0010); idle(8'h18, 4);

        tag = "R6";
        step(1'b1, 8'h28, 5); step(1'b1, 8'h64, 1);
        step(1'b1, 8'h10, 16'h0012); idle(8'h58, 10); idle(8'h1C, 20);
        tag = "R9";
        step(1'b0, 8'h58, 0);
        step(1'b1, 8'h58, model_read(8'h58)); idle(8'h58, 3);
        step(1'b1, 8'h28, 0); idle(8'h58, 3);
        step(1'b1, 8'h58, 16'h001F); idle(8'h58, 3);
        step(1'b1, 8'h10, 16'h0001); step(1'b1, 8'h58, 16'h001F); idle(8'h58, 3);

        tag = "R8";
        step(1'b1, 8'h38, 3); step(1'b1, 8'h50, 7); step(1'b1, 8'h68, 0);
        step(1'b1, 8'h14, 16'h0018); idle(8'h5C, 12);
        step(1'b1, 8'h68, 16'h000E); idle(8'h5C, 3);

        tag = "R7";
        step(1'b1, 8'h08, 16'h0001); step(1'b1, 8'h14, 16'h0010); idle(8'h20, 20);
        step(1'b1, 8'h08, 16'h0005); step(1'b1, 8'h14, 16'h0010); idle(8'h20, 40);
        step(1'b1, 8'h14, 16'h0001); idle(8'h20, 6);
        step(1'b1, 8'h14, 16'h0000); idle(8'h20, 10);

        tag = "R5";
        step(1'b1, 8'h60, 16'h0010); step(1'b1, 8'h0C, 16'h0010);
        idle(8'h54, 65545);
        step(1'b1, 8'h54, 16'h0010); idle(8'h54, 3);

        finish_run();
    end
endmodule